// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five software localities owns a shared secure peripheral at any moment. Every locality sees its own 4 KB register window. The locality number comes from the upper address bits, and the window holds one 8-bit access register. A locality writes a request bit to ask for ownership. The owner writes a release bit to give ownership up. The arbiter holds a single ownership token, so at most one locality is active at a time.

The arbiter keeps the requests that arrive while another locality owns the peripheral and shows them to the owner as a pending flag. When the owner releases, the token goes straight to the highest-numbered requester. Each change of owner raises a one-cycle event pulse for the interrupt logic. The active locality number goes out to the rest of the peripheral. A readiness flag stays low for a fixed number of cycles after reset, modelling self-initialization. Until it rises, the arbiter accepts nothing.

Register access is a plain single-cycle interface. A write completes in the cycle `bus_wr` is high, and a read returns data combinationally from `bus_addr`. There is no valid/ready handshake and no back-pressure, because every access finishes at once. The control and status outputs are plain levels and pulses.

Top module: `loc_arbiter`

## Requirements
- R1: The locality index is `bus_addr[15:12]`, and the access register sits only at offset 0x000 of its window. Windows 5 to 15 and every nonzero offset read 0x00, and writes to them change nothing.
- R2: Access register bit 7 and `ready_o` read 0 from reset. They become 1 exactly `INIT_CYCLES` rising clock edges after reset is released and stay 1 after that.
- R3: Any write made while bit 7 is 0 is ignored.
- R4: When no locality is active, a write with bit 1 set from a locality makes that locality the owner. The new owner is visible in the next cycle.
- R5: Bit 5 reads 1 only in the owner's window. `active_vld` is 1 while an owner exists, and `active_loc` gives the owner's number (0 when there is none).
- R6: A request write from a non-owner while another locality is active is held. That locality's bit 1 reads 1 until it is granted, and the owner's bit 2 reads 1 while any request is held.
- R7: A request write from the current owner has no effect.
- R8: A write with bit 5 set from the owner releases ownership. In the next cycle the highest-numbered held request becomes the owner, or no locality is active if none was held.
- R9: A write with bit 5 set from a locality that is not the owner has no effect.
- R10: `loc_change` is high for exactly the one cycle in which a changed ownership state first becomes visible, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register address: locality in 15:12, offset in 11:0 |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Access register contents at `bus_addr` (combinational) |
| ready_o | output | 1 | Initialization complete (mirrors bit 7) |
| active_vld | output | 1 | Some locality owns the peripheral |
| active_loc | output | 3 | Number of the owning locality |
| loc_change | output | 1 | One-cycle pulse when ownership changes |

## Verification
The grant logic is tried on four patterns, and each one isolates a single decision. The first is a request into an idle arbiter, which shows an immediate grant. The second is a request from the owner itself, which shows the ignore path. The third is several held requests followed by a release, which shows the highest-number choice and the handoff without an idle cycle. The fourth is a release with nothing held, which shows the return to the ownerless state. Release writes from non-owners, and writes to out-of-range windows or nonzero offsets, show whether the owner match and the address decode reject them. A request written during initialization shows whether writes before the valid flag rises are held off.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int ACC_W          = 8;
  localparam int ACC_VALID_BIT  = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_PEND_BIT   = 2;
  localparam int ACC_REQ_BIT    = 1;
endpackage

// File: rtl/loc_init_timer.sv
module loc_init_timer #(
  parameter int INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(INIT_CYCLES - 1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/loc_decode.sv
module loc_decode #(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 12
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_LOC-1:0] sel
);
  localparam int LSEL_W = ADDR_W - WIN_SHIFT;

  logic [LSEL_W-1:0]    win;
  logic [WIN_SHIFT-1:0] ofs;

  assign win = addr[ADDR_W-1:WIN_SHIFT];
  assign ofs = addr[WIN_SHIFT-1:0];

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_win
    assign sel[l] = (ofs == '0) && (win == LSEL_W'(l));
  end
endmodule

// File: rtl/loc_grant.sv
module loc_grant #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic [NUM_LOC-1:0] wr_sel,
  input  logic               wr_req,
  input  logic               wr_rel,
  output logic               owner_vld,
  output logic [LOC_W-1:0]   owner_idx,
  output logic [NUM_LOC-1:0] req_q,
  output logic               change
);
  logic [NUM_LOC-1:0] is_owner;
  logic [NUM_LOC-1:0] req_set;
  logic [NUM_LOC-1:0] req_all;
  logic [NUM_LOC-1:0] req_n;
  logic               rel;
  logic               vld_n;
  logic [LOC_W-1:0]   idx_n;
  logic [LOC_W-1:0]   top;

  function automatic logic [LOC_W-1:0] pick_top(input logic [NUM_LOC-1:0] v);
    pick_top = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (v[i]) pick_top = LOC_W'(i);
  endfunction

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_own
    assign is_owner[l] = owner_vld && (owner_idx == LOC_W'(l));
    assign req_set[l]  = ready && wr_sel[l] && wr_req && !is_owner[l];
  end

  assign rel     = ready && wr_rel && |(wr_sel & is_owner);
  assign req_all = req_q | req_set;
  assign top     = pick_top(req_all);

  always_comb begin
    req_n = req_all;
    vld_n = owner_vld;
    idx_n = owner_idx;
    if (rel || !owner_vld) begin
      if (|req_all) begin
        vld_n = 1'b1;
        idx_n = top;
        req_n = req_all & ~(NUM_LOC'(1) << top);
      end else begin
        vld_n = 1'b0;
        idx_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_idx <= '0;
      req_q     <= '0;
      change    <= 1'b0;
    end else begin
      owner_vld <= vld_n;
      owner_idx <= idx_n;
      req_q     <= req_n;
      change    <= (vld_n != owner_vld) || (idx_n != owner_idx);
    end
  end
endmodule

// File: rtl/loc_readback.sv
module loc_readback
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               ready,
  input  logic [NUM_LOC-1:0] rd_sel,
  input  logic               owner_vld,
  input  logic [LOC_W-1:0]   owner_idx,
  input  logic [NUM_LOC-1:0] req_q,
  output logic [ACC_W-1:0]   rdata
);
  logic [ACC_W-1:0] win_val [NUM_LOC];

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_val
    logic mine;
    assign mine = owner_vld && (owner_idx == LOC_W'(l));
    always_comb begin
      win_val[l]                 = '0;
      win_val[l][ACC_VALID_BIT]  = ready;
      win_val[l][ACC_ACTIVE_BIT] = mine;
      win_val[l][ACC_PEND_BIT]   = mine && (|req_q);
      win_val[l][ACC_REQ_BIT]    = req_q[l];
    end
  end

  always_comb begin
    rdata = '0;
    for (int l = 0; l < NUM_LOC; l++)
      if (rd_sel[l]) rdata = win_val[l];
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC     = 5,
  parameter int ADDR_W      = 16,
  parameter int WIN_SHIFT   = 12,
  parameter int INIT_CYCLES = 16,
  parameter int LOC_W       = $clog2(NUM_LOC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [ACC_W-1:0]  bus_wdata,
  output logic [ACC_W-1:0]  bus_rdata,
  output logic              ready_o,
  output logic              active_vld,
  output logic [LOC_W-1:0]  active_loc,
  output logic              loc_change
);
  logic [NUM_LOC-1:0] sel;
  logic [NUM_LOC-1:0] wr_sel;
  logic [NUM_LOC-1:0] req_q;

  loc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready_o)
  );

  loc_decode #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_sel = bus_wr ? sel : '0;

  loc_grant #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready_o),
    .wr_sel    (wr_sel),
    .wr_req    (bus_wdata[ACC_REQ_BIT]),
    .wr_rel    (bus_wdata[ACC_ACTIVE_BIT]),
    .owner_vld (active_vld),
    .owner_idx (active_loc),
    .req_q     (req_q),
    .change    (loc_change)
  );

  loc_readback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rb (
    .ready     (ready_o),
    .rd_sel    (sel),
    .owner_vld (active_vld),
    .owner_idx (active_loc),
    .req_q     (req_q),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 16,
  parameter int LOC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              ready_o,
  input logic              active_vld,
  input logic [LOC_W-1:0]  active_loc,
  input logic              loc_change
);
  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // R3
  no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !active_vld);

  // R5
  owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_vld |-> ({1'b0, active_loc} < (LOC_W+1)'(NUM_LOC)));

  // R10
  change_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_change |-> (($past(active_vld) != active_vld) || ($past(active_loc) != active_loc)));

  // R10
  change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(active_vld) != active_vld) || ($past(active_loc) != active_loc)) |-> loc_change);

  // R8
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(active_vld) && $stable(active_loc)));
endmodule

bind loc_arbiter loc_arbiter_chk #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_W(LOC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .ready_o    (ready_o),
  .active_vld (active_vld),
  .active_loc (active_loc),
  .loc_change (loc_change)
);

// File: tb/tb_loc_arbiter.sv
`timescale 1ns/1ps
module tb_loc_arbiter;
  localparam int INIT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ready_o;
  logic        active_vld;
  logic [2:0]  active_loc;
  logic        loc_change;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  loc_arbiter #(.INIT_CYCLES(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready_o(ready_o),
    .active_vld(active_vld), .active_loc(active_loc), .loc_change(loc_change)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc_wr(input int win, input int ofs, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = {win[3:0], ofs[11:0]};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic acc_rd(input int win, input int ofs, output logic [7:0] d);
    bus_addr = {win[3:0], ofs[11:0]};
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_owner(input string tag, input int vld, input int loc, input int chg);
    chk({tag, " active_vld"}, active_vld, vld);
    chk({tag, " active_loc"}, active_loc, loc);
    chk({tag, " loc_change"}, loc_change, chg);
  endtask

  task automatic t_reset_init();
    logic [7:0] d;
    int n;
    chk("R2 reset ready_o", ready_o, 0);
    chk_owner("R5 reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 16'h0000; bus_wdata = 8'h02; bus_wr = 1'b1;
    n = 0;
    for (int i = 0; i < 4 * INIT; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      bus_wr = 1'b0;
      if (n == 1) begin
        acc_rd(0, 0, d);
        chk("R2 valid bit low during init", d, 8'h00);
      end
      if (ready_o) break;
    end
    chk("R2 init cycle count", n, INIT);
    chk("R3 early request ignored", active_vld, 0);
    acc_rd(0, 0, d);
    chk("R2 valid bit after init", d, 8'h80);
  endtask

  task automatic t_idle_grant();
    logic [7:0] d;
    acc_wr(2, 0, 8'h02);
    chk_owner("R4 R10 idle grant", 1, 2, 1);
    acc_rd(2, 0, d); chk("R5 owner window", d, 8'hA0);
    acc_rd(0, 0, d); chk("R5 other window", d, 8'h80);
    @(negedge clk);
    chk("R10 pulse one cycle", loc_change, 0);
  endtask

  task automatic t_owner_rerequest();
    logic [7:0] d;
    acc_wr(2, 0, 8'h02);
    chk_owner("R7 owner request ignored", 1, 2, 0);
    acc_rd(2, 0, d); chk("R7 no pending from owner", d, 8'hA0);
  endtask

  task automatic t_pending();
    logic [7:0] d;
    acc_wr(1, 0, 8'h02);
    acc_wr(4, 0, 8'h02);
    chk_owner("R6 owner kept", 1, 2, 0);
    acc_rd(2, 0, d); chk("R6 owner sees pending", d, 8'hA4);
    acc_rd(1, 0, d); chk("R6 requester bit1", d, 8'h82);
    acc_rd(3, 0, d); chk("R6 idle locality", d, 8'h80);
  endtask

  task automatic t_release_chain();
    logic [7:0] d;
    acc_wr(1, 0, 8'h20);
    chk_owner("R9 non-owner release ignored", 1, 2, 0);
    acc_wr(2, 0, 8'h20);
    chk_owner("R8 release to highest", 1, 4, 1);
    acc_rd(4, 0, d); chk("R8 new owner sees pending", d, 8'hA4);
    acc_rd(2, 0, d); chk("R8 old owner cleared", d, 8'h80);
    acc_wr(4, 0, 8'h20);
    chk_owner("R8 second handoff", 1, 1, 1);
    acc_rd(1, 0, d); chk("R8 owner no pending", d, 8'hA0);
    acc_wr(1, 0, 8'h20);
    chk_owner("R8 R10 release to none", 0, 0, 1);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    acc_wr(5, 0, 8'h02);
    chk_owner("R1 window 5 ignored", 0, 0, 0);
    acc_wr(3, 8, 8'h02);
    chk_owner("R1 offset 8 ignored", 0, 0, 0);
    acc_rd(3, 8, d);  chk("R1 offset read zero", d, 8'h00);
    acc_rd(15, 0, d); chk("R1 window 15 read zero", d, 8'h00);
    acc_rd(3, 0, d);  chk("R1 no stray request", d, 8'h80);
    acc_wr(0, 0, 8'h02);
    chk_owner("R4 locality 0 grant", 1, 0, 1);
    acc_wr(3, 0, 8'h02);
    acc_rd(0, 0, d); chk("R6 locality 0 pending", d, 8'hA4);
    acc_wr(0, 0, 8'h22);
    chk_owner("R8 release with self request", 1, 3, 1);
    acc_rd(0, 0, d); chk("R7 self request dropped", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_init();
    t_idle_grant();
    t_owner_rerequest();
    t_pending();
    t_release_chain();
    t_decode();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule